// File: doc/BRIEF.md
# March-Test Memory Self-Test Controller

This block runs a fixed march-style self-test on one single-port synchronous RAM and records the algorithm step at which the first failure appeared. After a start pulse it drives the RAM address, write enable, read enable and write data. It issues one memory operation per cycle, checks every read word against the expected background and, at the end, reports pass or fail together with the captured failure record.

The built-in algorithm has four march elements. Element 0 writes zeros in ascending order. Element 1 runs in ascending order and, at each address, reads and expects zeros, then writes ones. Element 2 runs in descending order and, at each address, reads and expects ones, then writes zeros. Element 3 reads and expects zeros in ascending order. An element that may run in either direction always uses ascending order. The failure record holds the element index, the operation index within the element, the address, the expected word and the word actually read. A tester can log failures per algorithm step, and this data shows later which steps never catch a defect and can be dropped.

The controller is split into four parts: an address sequencer, an element and operation state machine, a data and control generator, and a comparator with an error latch.

Top module: `mbist_march_ctrl`

## Requirements
- R1: After reset, done_o, pass_o, fail_o, ram_we_o and ram_re_o are all low.
- R2: The operations run in this order. Element 0 is (write 0). Element 1 is (read 0, write 1). Element 2 is (read 1, write 0). Element 3 is (read 0). The element index counts 0 to 3. The operation index within an element is 0 for the first operation and 1 for the second. A write 0 drives all-zero data and a write 1 drives all-one data.
- R3: Elements 0, 1 and 3 visit addresses 0 up to 2^AW-1. Element 2 visits addresses 2^AW-1 down to 0. At each address all of an element's operations finish before the address changes, and every address finishes before the next element starts.
- R4: The block performs exactly one memory operation per cycle for 6·2^AW cycles, starting in the cycle after start_i is sampled. It then has one idle cycle, and done_o is high for exactly one cycle, in cycle 6·2^AW+2 after the start edge.
- R5: Read data is sampled one cycle after the read is issued, which matches a RAM with one cycle of read latency.
- R6: Only the first mismatch is captured: its element, operation index, address, expected word and actual word. Later mismatches in the same run leave the record unchanged.
- R7: fail_o is set by the first mismatch. It stays set after done_o and is cleared only when the next start is accepted.
- R8: pass_o is high only while done_o is high, and only when the run had no mismatch.
- R9: A start_i pulse while a test is running has no effect on the operation sequence or on the timing of done_o.
- R10: After a mismatch the run still continues to completion with the same sequence and the same done_o timing.
- R11: ram_we_o and ram_re_o are never high in the same cycle, and write data is always all-zero or all-one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| ram_addr_o | output | AW | RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read enable |
| ram_wdata_o | output | DW | RAM write data |
| ram_rdata_i | input | DW | RAM read data, one cycle after read |
| done_o | output | 1 | One-cycle end-of-test pulse |
| pass_o | output | 1 | Test passed, valid with done_o |
| fail_o | output | 1 | Sticky failure flag |
| err_elem_o | output | 2 | Element of first mismatch |
| err_op_o | output | 1 | Operation index of first mismatch |
| err_addr_o | output | AW | Address of first mismatch |
| err_exp_o | output | DW | Expected word of first mismatch |
| err_act_o | output | DW | Word read at first mismatch |

## Verification
A wrong element or operation counter shows up at the RAM port in the very next cycle as an out-of-order address, a wrong enable or a wrong data background, so the scoreboard compares every operation as it is issued. A wrong address direction or terminal count also changes the total number of operations and moves done_o. A fault in the compare pipeline or in the error latch shows only after done_o, as a wrong record. For this reason faults are placed at both address ends, and a second, later mismatch is used to confirm that only the earlier one is recorded.

// File: rtl/mbist_pkg.sv
`timescale 1ns/1ps
package mbist_pkg;

  localparam int unsigned NUM_ELEM = 4;
  localparam int unsigned ELEM_W   = 2;
  localparam int unsigned OP_W     = 1;

  typedef enum logic [1:0] {
    OP_W0 = 2'd0,
    OP_R0 = 2'd1,
    OP_W1 = 2'd2,
    OP_R1 = 2'd3
  } mop_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_DONE
  } seq_st_e;

  // index of the last operation in an element
  function automatic logic [OP_W-1:0] elem_last_op(input logic [ELEM_W-1:0] e);
    case (e)
      2'd1, 2'd2: elem_last_op = 1'b1;
      default:    elem_last_op = 1'b0;
    endcase
  endfunction

  // descending order only for element 2; either-direction elements run up
  function automatic logic elem_desc(input logic [ELEM_W-1:0] e);
    elem_desc = (e == 2'd2);
  endfunction

  function automatic mop_e elem_op(input logic [ELEM_W-1:0] e, input logic [OP_W-1:0] o);
    case ({e, o})
      3'b000:  elem_op = OP_W0;
      3'b010:  elem_op = OP_R0;
      3'b011:  elem_op = OP_W1;
      3'b100:  elem_op = OP_R1;
      3'b101:  elem_op = OP_W0;
      3'b110:  elem_op = OP_R0;
      default: elem_op = OP_R0;
    endcase
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
`timescale 1ns/1ps
module mbist_addr_gen #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          load_desc_i,
  input  logic          step_i,
  input  logic          desc_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  localparam logic [AW-1:0] ADDR_MIN = '0;
  localparam logic [AW-1:0] ADDR_MAX = '1;
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= ADDR_MIN;
    end else if (load_i) begin
      addr_q <= load_desc_i ? ADDR_MAX : ADDR_MIN;
    end else if (step_i) begin
      addr_q <= desc_i ? addr_q - ADDR_ONE : addr_q + ADDR_ONE;
    end
  end

  assign addr_o = addr_q;
  assign last_o = desc_i ? (addr_q == ADDR_MIN) : (addr_q == ADDR_MAX);

endmodule

// File: rtl/mbist_seq.sv
`timescale 1ns/1ps
module mbist_seq (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         addr_last_i,
  output logic                         active_o,
  output logic [mbist_pkg::ELEM_W-1:0] elem_o,
  output logic [mbist_pkg::OP_W-1:0]   op_o,
  output logic                         load_o,
  output logic                         load_desc_o,
  output logic                         step_o,
  output logic                         desc_o,
  output logic                         clear_o,
  output logic                         done_o
);

  localparam int unsigned EW = mbist_pkg::ELEM_W;
  localparam int unsigned OW = mbist_pkg::OP_W;
  localparam logic [EW-1:0] ELEM_FIRST = '0;
  localparam logic [EW-1:0] ELEM_LAST  = EW'(mbist_pkg::NUM_ELEM - 1);
  localparam logic [EW-1:0] ELEM_ONE   = EW'(1);
  localparam logic [OW-1:0] OP_ONE     = OW'(1);

  mbist_pkg::seq_st_e st_q, st_d;
  logic [EW-1:0] elem_q, elem_d;
  logic [OW-1:0] op_q, op_d;

  logic run, start_acc, op_last, elem_last, elem_adv;
  logic [EW-1:0] elem_nxt;

  assign run       = (st_q == mbist_pkg::ST_RUN);
  assign start_acc = (st_q == mbist_pkg::ST_IDLE) && start_i;
  assign op_last   = (op_q == mbist_pkg::elem_last_op(elem_q));
  assign elem_last = (elem_q == ELEM_LAST);
  assign elem_nxt  = elem_q + ELEM_ONE;
  assign elem_adv  = run && op_last && addr_last_i && !elem_last;

  always_comb begin
    st_d   = st_q;
    elem_d = elem_q;
    op_d   = op_q;
    unique case (st_q)
      mbist_pkg::ST_IDLE: begin
        if (start_i) begin
          st_d   = mbist_pkg::ST_RUN;
          elem_d = ELEM_FIRST;
          op_d   = '0;
        end
      end
      mbist_pkg::ST_RUN: begin
        if (!op_last) begin
          op_d = op_q + OP_ONE;
        end else begin
          op_d = '0;
          if (addr_last_i) begin
            if (elem_last) st_d = mbist_pkg::ST_DRAIN;
            else           elem_d = elem_nxt;
          end
        end
      end
      mbist_pkg::ST_DRAIN: st_d = mbist_pkg::ST_DONE;
      mbist_pkg::ST_DONE:  st_d = mbist_pkg::ST_IDLE;
      default:             st_d = mbist_pkg::ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= mbist_pkg::ST_IDLE;
      elem_q <= ELEM_FIRST;
      op_q   <= '0;
    end else begin
      st_q   <= st_d;
      elem_q <= elem_d;
      op_q   <= op_d;
    end
  end

  assign active_o    = run;
  assign elem_o      = elem_q;
  assign op_o        = op_q;
  assign load_o      = start_acc || elem_adv;
  assign load_desc_o = start_acc ? mbist_pkg::elem_desc(ELEM_FIRST)
                                 : mbist_pkg::elem_desc(elem_nxt);
  assign step_o      = run && op_last && !addr_last_i;
  assign desc_o      = mbist_pkg::elem_desc(elem_q);
  assign clear_o     = start_acc;
  assign done_o      = (st_q == mbist_pkg::ST_DONE);

endmodule

// File: rtl/mbist_datagen.sv
`timescale 1ns/1ps
module mbist_datagen #(
  parameter int unsigned DW = 8
) (
  input  logic                         active_i,
  input  logic [mbist_pkg::ELEM_W-1:0] elem_i,
  input  logic [mbist_pkg::OP_W-1:0]   op_i,
  output logic                         we_o,
  output logic                         re_o,
  output logic [DW-1:0]                wdata_o,
  output logic [DW-1:0]                exp_o
);

  localparam logic [DW-1:0] BG_ZERO = '0;
  localparam logic [DW-1:0] BG_ONE  = '1;

  mbist_pkg::mop_e op;

  assign op = mbist_pkg::elem_op(elem_i, op_i);

  always_comb begin
    we_o    = 1'b0;
    re_o    = 1'b0;
    wdata_o = BG_ZERO;
    exp_o   = BG_ZERO;
    if (active_i) begin
      unique case (op)
        mbist_pkg::OP_W0: we_o = 1'b1;
        mbist_pkg::OP_W1: begin
          we_o    = 1'b1;
          wdata_o = BG_ONE;
        end
        mbist_pkg::OP_R0: re_o = 1'b1;
        mbist_pkg::OP_R1: begin
          re_o  = 1'b1;
          exp_o = BG_ONE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mbist_cmp.sv
`timescale 1ns/1ps
module mbist_cmp #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic                         re_i,
  input  logic [DW-1:0]                exp_i,
  input  logic [mbist_pkg::ELEM_W-1:0] elem_i,
  input  logic [mbist_pkg::OP_W-1:0]   op_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [DW-1:0]                rdata_i,
  output logic                         fail_o,
  output logic [mbist_pkg::ELEM_W-1:0] err_elem_o,
  output logic [mbist_pkg::OP_W-1:0]   err_op_o,
  output logic [AW-1:0]                err_addr_o,
  output logic [DW-1:0]                err_exp_o,
  output logic [DW-1:0]                err_act_o
);

  localparam int unsigned EW = mbist_pkg::ELEM_W;
  localparam int unsigned OW = mbist_pkg::OP_W;

  // read context held for one cycle of RAM latency
  logic          rd_vld_q;
  logic [DW-1:0] exp_q;
  logic [EW-1:0] elem_q;
  logic [OW-1:0] op_q;
  logic [AW-1:0] addr_q;

  logic          fail_q;
  logic [EW-1:0] e_elem_q;
  logic [OW-1:0] e_op_q;
  logic [AW-1:0] e_addr_q;
  logic [DW-1:0] e_exp_q, e_act_q;

  logic mismatch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q <= 1'b0;
      exp_q    <= '0;
      elem_q   <= '0;
      op_q     <= '0;
      addr_q   <= '0;
    end else begin
      rd_vld_q <= re_i;
      if (re_i) begin
        exp_q  <= exp_i;
        elem_q <= elem_i;
        op_q   <= op_i;
        addr_q <= addr_i;
      end
    end
  end

  assign mismatch = rd_vld_q && (rdata_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q   <= 1'b0;
      e_elem_q <= '0;
      e_op_q   <= '0;
      e_addr_q <= '0;
      e_exp_q  <= '0;
      e_act_q  <= '0;
    end else if (clear_i) begin
      fail_q   <= 1'b0;
      e_elem_q <= '0;
      e_op_q   <= '0;
      e_addr_q <= '0;
      e_exp_q  <= '0;
      e_act_q  <= '0;
    end else if (mismatch && !fail_q) begin
      fail_q   <= 1'b1;
      e_elem_q <= elem_q;
      e_op_q   <= op_q;
      e_addr_q <= addr_q;
      e_exp_q  <= exp_q;
      e_act_q  <= rdata_i;
    end
  end

  assign fail_o     = fail_q;
  assign err_elem_o = e_elem_q;
  assign err_op_o   = e_op_q;
  assign err_addr_o = e_addr_q;
  assign err_exp_o  = e_exp_q;
  assign err_act_o  = e_act_q;

endmodule

// File: rtl/mbist_march_ctrl.sv
`timescale 1ns/1ps
module mbist_march_ctrl #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  output logic [AW-1:0]                ram_addr_o,
  output logic                         ram_we_o,
  output logic                         ram_re_o,
  output logic [DW-1:0]                ram_wdata_o,
  input  logic [DW-1:0]                ram_rdata_i,
  output logic                         done_o,
  output logic                         pass_o,
  output logic                         fail_o,
  output logic [mbist_pkg::ELEM_W-1:0] err_elem_o,
  output logic [mbist_pkg::OP_W-1:0]   err_op_o,
  output logic [AW-1:0]                err_addr_o,
  output logic [DW-1:0]                err_exp_o,
  output logic [DW-1:0]                err_act_o
);

  localparam int unsigned EW = mbist_pkg::ELEM_W;
  localparam int unsigned OW = mbist_pkg::OP_W;

  logic          active, load, load_desc, step, desc, addr_last, clear, done;
  logic [EW-1:0] elem;
  logic [OW-1:0] op;
  logic [AW-1:0] addr;
  logic [DW-1:0] exp_bg;
  logic          we, re, fail;

  mbist_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .addr_last_i (addr_last),
    .active_o    (active),
    .elem_o      (elem),
    .op_o        (op),
    .load_o      (load),
    .load_desc_o (load_desc),
    .step_o      (step),
    .desc_o      (desc),
    .clear_o     (clear),
    .done_o      (done)
  );

  mbist_addr_gen #(.AW(AW)) i_addr_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_desc_i (load_desc),
    .step_i      (step),
    .desc_i      (desc),
    .addr_o      (addr),
    .last_o      (addr_last)
  );

  mbist_datagen #(.DW(DW)) i_datagen (
    .active_i (active),
    .elem_i   (elem),
    .op_i     (op),
    .we_o     (we),
    .re_o     (re),
    .wdata_o  (ram_wdata_o),
    .exp_o    (exp_bg)
  );

  mbist_cmp #(.AW(AW), .DW(DW)) i_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .re_i       (re),
    .exp_i      (exp_bg),
    .elem_i     (elem),
    .op_i       (op),
    .addr_i     (addr),
    .rdata_i    (ram_rdata_i),
    .fail_o     (fail),
    .err_elem_o (err_elem_o),
    .err_op_o   (err_op_o),
    .err_addr_o (err_addr_o),
    .err_exp_o  (err_exp_o),
    .err_act_o  (err_act_o)
  );

  assign ram_addr_o = addr;
  assign ram_we_o   = we;
  assign ram_re_o   = re;
  assign done_o     = done;
  assign fail_o     = fail;
  assign pass_o     = done && !fail;

endmodule

// File: rtl/mbist_march_chk.sv
`timescale 1ns/1ps
module mbist_march_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          ram_we_o,
  input logic          ram_re_o,
  input logic [DW-1:0] ram_wdata_o,
  input logic          done_o,
  input logic          pass_o,
  input logic          fail_o,
  input logic [AW-1:0] err_addr_o
);

  assert_we_re_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ram_re_o));

  assert_wdata_bg_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_wdata_o == '0 || ram_wdata_o == '1));

  assert_pass_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o);

  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(ram_we_o || ram_re_o));

  assert_fail_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fail_o) |-> $past(start_i));

  assert_record_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && $past(fail_o)) |-> $stable(err_addr_o));

endmodule

bind mbist_march_ctrl mbist_march_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .ram_we_o    (ram_we_o),
  .ram_re_o    (ram_re_o),
  .ram_wdata_o (ram_wdata_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .fail_o      (fail_o),
  .err_addr_o  (err_addr_o)
);

// File: tb/test_mbist_march_ctrl.sv
`timescale 1ns/1ps
module test_mbist_march_ctrl;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int RUN_CYC = 6 * N + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] ram_addr;
  logic          ram_we, ram_re;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata = '0;
  logic          done, pass, fail;
  logic [1:0]    err_elem;
  logic          err_op;
  logic [AW-1:0] err_addr;
  logic [DW-1:0] err_exp, err_act;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mbist_march_ctrl #(.AW(AW), .DW(DW)) i_mbist_march_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .ram_addr_o  (ram_addr),
    .ram_we_o    (ram_we),
    .ram_re_o    (ram_re),
    .ram_wdata_o (ram_wdata),
    .ram_rdata_i (ram_rdata),
    .done_o      (done),
    .pass_o      (pass),
    .fail_o      (fail),
    .err_elem_o  (err_elem),
    .err_op_o    (err_op),
    .err_addr_o  (err_addr),
    .err_exp_o   (err_exp),
    .err_act_o   (err_act)
  );

  // RAM model with one cycle read latency and per-address stuck bits
  logic [DW-1:0] mem [N];
  logic [DW-1:0] sa1 [N];
  logic [DW-1:0] sa0 [N];

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= (ram_wdata | sa1[ram_addr]) & ~sa0[ram_addr];
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [AW-1:0] a;
    logic          we;
    logic [DW-1:0] wd;
  } exp_op_t;

  exp_op_t sb[$];

  task automatic push_op(input int a, input bit we, input bit one);
    exp_op_t e;
    e.a  = AW'(a);
    e.we = we;
    e.wd = one ? '1 : '0;
    sb.push_back(e);
  endtask

  // driver: expected operation stream of the test (R2, R3)
  task automatic push_march();
    for (int a = 0; a < N; a++) push_op(a, 1'b1, 1'b0);
    for (int a = 0; a < N; a++) begin
      push_op(a, 1'b0, 1'b0);
      push_op(a, 1'b1, 1'b1);
    end
    for (int a = N - 1; a >= 0; a--) begin
      push_op(a, 1'b0, 1'b1);
      push_op(a, 1'b1, 1'b0);
    end
    for (int a = 0; a < N; a++) push_op(a, 1'b0, 1'b0);
  endtask

  // monitor: pops one expected item per memory operation
  always @(negedge clk) begin
    if (rst_n && (ram_we || ram_re)) begin
      chk(!(ram_we && ram_re), "R11", "we and re together", {ram_we, ram_re}, 2'b00);
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "unexpected memory operation", ram_addr, 0);
      end else begin
        exp_op_t e;
        e = sb.pop_front();
        chk(ram_addr == e.a, "R3", "address order", ram_addr, e.a);
        chk(ram_we == e.we, "R2", "operation kind", ram_we, e.we);
        if (e.we) chk(ram_wdata == e.wd, "R2", "write data", ram_wdata, e.wd);
      end
    end
  end

  task automatic clear_faults();
    for (int a = 0; a < N; a++) begin
      sa1[a] = '0;
      sa0[a] = '0;
    end
  endtask

  task automatic run_march(input int restart_at, output int cycles, output bit fail_c1);
    push_march();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cycles  = 1;
    fail_c1 = fail;
    while (!done && cycles < 1000) begin
      @(negedge clk);
      cycles++;
      start = (cycles == restart_at);
    end
    start = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "R4", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int  cyc;
    bit  f1;
    for (int a = 0; a < N; a++) mem[a] = '0;
    clear_faults();
    repeat (3) @(negedge clk);
    chk(!done && !pass && !fail && !ram_we && !ram_re, "R1", "reset outputs",
        {done, pass, fail, ram_we, ram_re}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !fail && !ram_we && !ram_re, "R1", "idle after reset",
        {done, fail, ram_we, ram_re}, 0);

    // clean run
    run_march(0, cyc, f1);
    chk(cyc == RUN_CYC, "R4", "done cycle clean", cyc, RUN_CYC);
    chk(pass && !fail, "R8", "pass on clean run", {pass, fail}, 2'b10);
    chk(sb.size() == 0, "R4", "all ops issued", sb.size(), 0);
    @(negedge clk);
    chk(!done && !pass, "R4", "done one cycle", {done, pass}, 0);

    // stuck-at-1 at addr 5 bit 3, plus a restart request mid-run
    sa1[5] = 8'h08;
    run_march(30, cyc, f1);
    chk(cyc == RUN_CYC, "R9", "done cycle with ignored restart", cyc, RUN_CYC);
    chk(cyc == RUN_CYC, "R10", "run completes after failure", cyc, RUN_CYC);
    chk(!pass && fail, "R8", "no pass on failure", {pass, fail}, 2'b01);
    chk(err_elem == 2'd1, "R6", "elem of first fail", err_elem, 1);
    chk(err_op == 1'b0, "R6", "op of first fail", err_op, 0);
    chk(err_addr == 4'd5, "R6", "addr of first fail", err_addr, 5);
    chk(err_exp == 8'h00, "R6", "expected word", err_exp, 8'h00);
    chk(err_act == 8'h08, "R5", "actual word latched", err_act, 8'h08);
    repeat (20) @(negedge clk);
    chk(fail && !done, "R7", "fail sticky after done", {fail, done}, 2'b10);
    chk(sb.size() == 0, "R9", "no extra run started", sb.size(), 0);

    // stuck-at-0 at both ends: descending element hits the top one first
    clear_faults();
    sa0[0]     = 8'h01;
    sa0[N - 1] = 8'h80;
    run_march(0, cyc, f1);
    chk(!f1, "R7", "fail cleared by start", f1, 0);
    chk(cyc == RUN_CYC, "R10", "done cycle second fault", cyc, RUN_CYC);
    chk(fail && !pass, "R7", "fail set", {fail, pass}, 2'b10);
    chk(err_elem == 2'd2, "R6", "elem descending fail", err_elem, 2);
    chk(err_op == 1'b0, "R6", "op descending fail", err_op, 0);
    chk(err_addr == AW'(N - 1), "R3", "descending starts at top", err_addr, N - 1);
    chk(err_exp == 8'hFF, "R6", "expected ones", err_exp, 8'hFF);
    chk(err_act == 8'h7F, "R5", "actual stuck-at-0", err_act, 8'h7F);

    // clean again: pass restored
    clear_faults();
    repeat (3) @(negedge clk);
    run_march(0, cyc, f1);
    chk(!f1, "R7", "fail cleared on restart", f1, 0);
    chk(pass && !fail, "R8", "pass after fault removed", {pass, fail}, 2'b10);
    chk(cyc == RUN_CYC, "R4", "done cycle final", cyc, RUN_CYC);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule